// File: doc/BRIEF.md
# Exception Return State Update Unit

This unit performs the privileged-state commit that takes place when a processor leaves an exception handler, an interrupt handler or an error trap. A one-cycle request carries a flag that selects one of two return variants. The clearing variant drops the load-linked reservation. The non-clearing variant keeps the reservation, so that an interrupted load-linked/store-conditional pair can still succeed. Both variants share one datapath. That datapath picks the saved return address, clears the right privilege-level flag, can restore the current shadow register set from the previous one, splits the target into a fetch address and an ISA mode bit, and raises a redirect pulse and a hazard-clear pulse. The redirect pulse squashes the instruction that follows the return, because the return has no delay slot.

A request made from user mode while coprocessor 0 is disabled is refused. The unit raises a coprocessor-unusable fault for one cycle and changes nothing. When no request is present, the status, shadow-set and reservation outputs follow their inputs through one register, so the block can sit in line with the status register path. A small state machine tracks the kind of event in the last cycle. It has three states. ST_IDLE means no event. ST_RETURN means a return was accepted, and both pulses are high. ST_FAULT means a request was refused. From any state the next state is chosen by the same rule: an accepted request goes to ST_RETURN, a refused request goes to ST_FAULT, and no request goes to ST_IDLE. Back-to-back requests are therefore served every cycle.

Top module: `eret_state_unit`

## Requirements
- R1: When a request is accepted with the error-level input set, the fetch target is taken from the error return address, the error-level output becomes 0, and the exception-level output keeps its input value.
- R2: When a request is accepted with the error-level input clear, the fetch target is taken from the exception return address and the exception-level output becomes 0.
- R3: On an accepted return through the exception-level path, the current shadow set output takes the previous shadow set only when all three hold: the architecture revision parameter is at least 2, the highest-shadow-set input is nonzero, and the boot-vector flag is 0. In every other case it keeps the current shadow set input.
- R4: With a compressed ISA present, the fetch address is the target with bit 0 forced to 0, and the ISA mode output is target bit 0. Without one, the fetch address is the full target and the ISA mode output is 0.
- R5: An accepted clearing return (keep flag 0) makes the reservation output 0. An accepted non-clearing return (keep flag 1) leaves it equal to the reservation input.
- R6: The capability output is 1 exactly when non-clearing support is built in. When support is not built in, a request with the keep flag set clears the reservation like a clearing return.
- R7: Redirect and hazard-clear are high for exactly the one cycle after an accepted request, and that is the cycle in which the new fetch address and ISA mode appear.
- R8: A request with user mode 1 and the coprocessor-0 enable 0 raises the fault output for the following cycle. It raises no redirect, and every status, shadow-set, reservation, address and mode output takes the value it would take with no request.
- R9: A synchronous reset sets all outputs to 0, except the capability output.
- R10: Without an accepted request, the status, shadow-set and reservation outputs equal their inputs one cycle later, and the fetch address and ISA mode keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | One-cycle return request |
| req_keep_ll_i | input | 1 | 1 selects the non-clearing variant |
| erl_i | input | 1 | Current error-level flag |
| exl_i | input | 1 | Current exception-level flag |
| bev_i | input | 1 | Boot exception vector flag |
| user_mode_i | input | 1 | Processor is in user mode |
| cu0_en_i | input | 1 | Coprocessor 0 usable in user mode |
| ll_i | input | 1 | Current load-linked reservation |
| hss_i | input | SW | Highest shadow set implemented |
| pss_i | input | SW | Previous shadow set |
| css_i | input | SW | Current shadow set |
| epc_i | input | AW | Exception return address |
| errpc_i | input | AW | Error return address |
| pc_o | output | AW | New fetch address |
| isa_mode_o | output | 1 | ISA mode after return |
| erl_o | output | 1 | Updated error-level flag |
| exl_o | output | 1 | Updated exception-level flag |
| css_o | output | SW | Updated current shadow set |
| ll_o | output | 1 | Updated reservation |
| redirect_o | output | 1 | Fetch redirect and squash of the next instruction |
| hazard_clr_o | output | 1 | Execution and instruction hazard clear |
| fault_o | output | 1 | Coprocessor-unusable fault |
| nc_cap_o | output | 1 | Non-clearing variant implemented |

## Verification
The hardest case to reach is the shadow-set restore. It needs the exception-level path, a nonzero highest-set field and the boot-vector flag clear all at once, and each of these three can block it alone. The stimulus table includes rows that break exactly one condition at a time, and the previous and current set values differ in every row, so a restore that should not happen shows up as a changed output. A second instance is built with an older revision, no compressed ISA and no non-clearing support. It is driven with the same stimulus to cover the paths that only parameters select.

// File: rtl/eret_pkg.sv
package eret_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RETURN = 2'd1,
        ST_FAULT  = 2'd2
    } eret_state_e;

endpackage

// File: rtl/eret_fault_gate.sv
module eret_fault_gate (
    input  logic req_i,
    input  logic user_mode_i,
    input  logic cu0_en_i,
    output logic accept_o,
    output logic fault_o
);
    logic denied;

    always_comb begin
        denied   = user_mode_i & ~cu0_en_i;
        accept_o = req_i & ~denied;
        fault_o  = req_i & denied;
    end
endmodule

// File: rtl/eret_target_split.sv
module eret_target_split #(
    parameter int AW       = 32,
    parameter bit HAS_CISA = 1'b1
) (
    input  logic          erl_i,
    input  logic [AW-1:0] epc_i,
    input  logic [AW-1:0] errpc_i,
    output logic [AW-1:0] pc_o,
    output logic          isa_o
);
    logic [AW-1:0] target;

    always_comb target = erl_i ? errpc_i : epc_i;

    generate
        if (HAS_CISA) begin : g_cisa
            always_comb begin
                pc_o  = {target[AW-1:1], 1'b0};
                isa_o = target[0];
            end
        end else begin : g_plain
            always_comb begin
                pc_o  = target;
                isa_o = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/eret_shadow_pick.sv
module eret_shadow_pick #(
    parameter int SW       = 4,
    parameter int ARCH_REV = 2
) (
    input  logic          accept_i,
    input  logic          erl_i,
    input  logic          bev_i,
    input  logic [SW-1:0] hss_i,
    input  logic [SW-1:0] pss_i,
    input  logic [SW-1:0] css_i,
    output logic [SW-1:0] css_next_o
);
    generate
        if (ARCH_REV >= 2) begin : g_restore
            logic swap;
            always_comb begin
                swap       = accept_i & ~erl_i & (hss_i != '0) & ~bev_i;
                css_next_o = swap ? pss_i : css_i;
            end
        end else begin : g_keep
            always_comb css_next_o = css_i;
        end
    endgenerate
endmodule

// File: rtl/eret_state_unit.sv
module eret_state_unit
    import eret_pkg::*;
#(
    parameter int AW           = 32,
    parameter int SW           = 4,
    parameter int ARCH_REV     = 2,
    parameter bit HAS_CISA     = 1'b1,
    parameter bit NC_SUPPORTED = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_i,
    input  logic          req_keep_ll_i,
    input  logic          erl_i,
    input  logic          exl_i,
    input  logic          bev_i,
    input  logic          user_mode_i,
    input  logic          cu0_en_i,
    input  logic          ll_i,
    input  logic [SW-1:0] hss_i,
    input  logic [SW-1:0] pss_i,
    input  logic [SW-1:0] css_i,
    input  logic [AW-1:0] epc_i,
    input  logic [AW-1:0] errpc_i,
    output logic [AW-1:0] pc_o,
    output logic          isa_mode_o,
    output logic          erl_o,
    output logic          exl_o,
    output logic [SW-1:0] css_o,
    output logic          ll_o,
    output logic          redirect_o,
    output logic          hazard_clr_o,
    output logic          fault_o,
    output logic          nc_cap_o
);
    localparam logic NC_ON = NC_SUPPORTED;

    eret_state_e   state_q, state_d;
    logic          accept, refuse;
    logic [AW-1:0] tgt_pc;
    logic          tgt_isa;
    logic [SW-1:0] css_next;
    logic          keep_ll;

    eret_fault_gate u_gate (
        .req_i       (req_i),
        .user_mode_i (user_mode_i),
        .cu0_en_i    (cu0_en_i),
        .accept_o    (accept),
        .fault_o     (refuse)
    );

    eret_target_split #(.AW(AW), .HAS_CISA(HAS_CISA)) u_target (
        .erl_i   (erl_i),
        .epc_i   (epc_i),
        .errpc_i (errpc_i),
        .pc_o    (tgt_pc),
        .isa_o   (tgt_isa)
    );

    eret_shadow_pick #(.SW(SW), .ARCH_REV(ARCH_REV)) u_shadow (
        .accept_i   (accept),
        .erl_i      (erl_i),
        .bev_i      (bev_i),
        .hss_i      (hss_i),
        .pss_i      (pss_i),
        .css_i      (css_i),
        .css_next_o (css_next)
    );

    always_comb keep_ll = req_keep_ll_i & NC_ON;

    // next-state rule, identical from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RETURN, ST_FAULT: begin
                if (accept)      state_d = ST_RETURN;
                else if (refuse) state_d = ST_FAULT;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // state-decoded pulses
    always_comb begin
        redirect_o   = 1'b0;
        hazard_clr_o = 1'b0;
        fault_o      = 1'b0;
        unique case (state_q)
            ST_RETURN: begin
                redirect_o   = 1'b1;
                hazard_clr_o = 1'b1;
            end
            ST_FAULT: fault_o = 1'b1;
            default: ;
        endcase
    end

    always_comb nc_cap_o = NC_ON;

    // registered state commit
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_o       <= '0;
            isa_mode_o <= 1'b0;
            erl_o      <= 1'b0;
            exl_o      <= 1'b0;
            css_o      <= '0;
            ll_o       <= 1'b0;
        end else begin
            css_o <= css_next;
            if (accept) begin
                pc_o       <= tgt_pc;
                isa_mode_o <= tgt_isa;
                erl_o      <= 1'b0;
                exl_o      <= erl_i ? exl_i : 1'b0;
                ll_o       <= keep_ll ? ll_i : 1'b0;
            end else begin
                erl_o <= erl_i;
                exl_o <= exl_i;
                ll_o  <= ll_i;
            end
        end
    end

    // assertions
    assert_erl_path_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && erl_i && !(user_mode_i && !cu0_en_i)) |=> (!erl_o && exl_o == $past(exl_i)));

    assert_exl_path_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !erl_i && !(user_mode_i && !cu0_en_i)) |=> (!exl_o && !erl_o));

    assert_keep_ll_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && req_keep_ll_i && NC_ON && !(user_mode_i && !cu0_en_i)) |=> (ll_o == $past(ll_i)));

    assert_clear_ll_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !req_keep_ll_i && !(user_mode_i && !cu0_en_i)) |=> !ll_o);

    assert_redirect_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !(user_mode_i && !cu0_en_i)) |=> (redirect_o && hazard_clr_o && !fault_o));

    assert_fault_inert_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && user_mode_i && !cu0_en_i) |=> (fault_o && !redirect_o && $stable(pc_o)
                                                 && erl_o == $past(erl_i) && ll_o == $past(ll_i)));

    assert_one_event_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({redirect_o, fault_o}));

    generate
        if (HAS_CISA) begin : g_chk_cisa
            assert_pc_even_R4: assert property (@(posedge clk_i) disable iff (rst_i)
                redirect_o |-> !pc_o[0]);
        end
    endgenerate
endmodule

// File: tb/tb_eret_state_unit.sv
`timescale 1ns/1ps
module tb_eret_state_unit;
    localparam int AW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst, req, keep, erl, exl, bev, um, cu0, ll;
    logic [SW-1:0] hss, pss, css;
    logic [AW-1:0] epc, errpc;

    logic [AW-1:0] pc_o, pc_m;
    logic          isa_o, erl_o, exl_o, ll_o, red_o, haz_o, flt_o, cap_o;
    logic [SW-1:0] css_o, css_m;
    logic          isa_m, erl_m, exl_m, ll_m, red_m, haz_m, flt_m, cap_m;

    eret_state_unit dut (
        .clk_i(clk), .rst_i(rst), .req_i(req), .req_keep_ll_i(keep),
        .erl_i(erl), .exl_i(exl), .bev_i(bev), .user_mode_i(um), .cu0_en_i(cu0),
        .ll_i(ll), .hss_i(hss), .pss_i(pss), .css_i(css), .epc_i(epc), .errpc_i(errpc),
        .pc_o(pc_o), .isa_mode_o(isa_o), .erl_o(erl_o), .exl_o(exl_o), .css_o(css_o),
        .ll_o(ll_o), .redirect_o(red_o), .hazard_clr_o(haz_o), .fault_o(flt_o),
        .nc_cap_o(cap_o));

    eret_state_unit #(.ARCH_REV(1), .HAS_CISA(1'b0), .NC_SUPPORTED(1'b0)) dut_min (
        .clk_i(clk), .rst_i(rst), .req_i(req), .req_keep_ll_i(keep),
        .erl_i(erl), .exl_i(exl), .bev_i(bev), .user_mode_i(um), .cu0_en_i(cu0),
        .ll_i(ll), .hss_i(hss), .pss_i(pss), .css_i(css), .epc_i(epc), .errpc_i(errpc),
        .pc_o(pc_m), .isa_mode_o(isa_m), .erl_o(erl_m), .exl_o(exl_m), .css_o(css_m),
        .ll_o(ll_m), .redirect_o(red_m), .hazard_clr_o(haz_m), .fault_o(flt_m),
        .nc_cap_o(cap_m));

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // {erl,exl,bev,um,cu0,keep,ll, hss, pss, css, epc, errpc}
    localparam int VW = 7 + 3*SW + 2*AW;
    localparam logic [VW-1:0] VEC [0:7] = '{
        {7'b1100101, 4'd3, 4'd2, 4'd1, 32'h0000_1001, 32'hBFC0_0203},
        {7'b0100101, 4'd3, 4'd2, 4'd1, 32'h8000_0181, 32'h1111_1110},
        {7'b0110111, 4'd3, 4'd5, 4'd1, 32'h8000_0240, 32'h2222_2222},
        {7'b0100111, 4'd0, 4'd5, 4'd4, 32'h8000_0333, 32'h3333_3333},
        {7'b0101001, 4'd3, 4'd2, 4'd1, 32'h4444_4445, 32'h5555_5555},
        {7'b0101101, 4'd3, 4'd6, 4'd0, 32'h0040_0007, 32'h6666_6666},
        {7'b1000010, 4'd2, 4'd7, 4'd3, 32'h7777_7777, 32'h0000_0A01},
        {7'b1101011, 4'd1, 4'd9, 4'd8, 32'h0000_0B0B, 32'h0000_0C0D}
    };

    logic [AW-1:0] exp_pc;
    logic          exp_isa;

    task automatic apply(input logic [VW-1:0] v, input logic r);
        {erl, exl, bev, um, cu0, keep, ll, hss, pss, css, epc, errpc} = v;
        req = r;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        apply({7'b1111111, 4'hF, 4'hF, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, 1'b1);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 pc", pc_o, 0);
        chk("R9 flags", {isa_o, erl_o, exl_o, ll_o, red_o, haz_o, flt_o}, 0);
        chk("R9 css", css_o, 0);
        chk("R6 cap full", cap_o, 1);
        chk("R6 cap min", cap_m, 0);
        rst = 1'b0;
        req = 1'b0;
        @(negedge clk);
        exp_pc = '0;
        exp_isa = 1'b0;

        // table walk: every row as a request, then one idle cycle
        for (int i = 0; i < 8; i++) begin
            logic acc, e_erl, e_exl, e_ll;
            logic [SW-1:0] e_css;
            logic [AW-1:0] tgt;
            apply(VEC[i], 1'b1);
            acc   = !(um && !cu0);
            tgt   = erl ? errpc : epc;
            e_erl = acc ? 1'b0 : erl;
            e_exl = (acc && !erl) ? 1'b0 : exl;
            e_css = (acc && !erl && hss != 0 && !bev) ? pss : css;
            e_ll  = acc ? (keep ? ll : 1'b0) : ll;
            if (acc) begin
                exp_pc  = {tgt[AW-1:1], 1'b0};
                exp_isa = tgt[0];
            end
            @(negedge clk);
            chk($sformatf("R1/R2 row%0d erl", i), erl_o, e_erl);
            chk($sformatf("R1/R2 row%0d exl", i), exl_o, e_exl);
            chk($sformatf("R3 row%0d css", i), css_o, e_css);
            chk($sformatf("R4 row%0d pc", i), pc_o, exp_pc);
            chk($sformatf("R4 row%0d isa", i), isa_o, exp_isa);
            chk($sformatf("R5 row%0d ll", i), ll_o, e_ll);
            chk($sformatf("R7 row%0d redirect", i), {red_o, haz_o}, {acc, acc});
            chk($sformatf("R8 row%0d fault", i), flt_o, !acc);
            req = 1'b0;
            @(negedge clk);
            chk($sformatf("R7 row%0d pulse end", i), {red_o, haz_o, flt_o}, 0);
            chk($sformatf("R10 row%0d pc hold", i), pc_o, exp_pc);
        end

        // R10: idle pass-through
        apply({7'b1110011, 4'd3, 4'd2, 4'd9, 32'h0, 32'h0}, 1'b0);
        @(negedge clk);
        chk("R10 flags follow", {erl_o, exl_o, ll_o}, 3'b111);
        chk("R10 css follow", css_o, 9);

        // minimal variant: no restore, full address, keep flag ignored
        apply({7'b0100111, 4'd3, 4'd2, 4'd1, 32'h8000_0181, 32'h0}, 1'b1);
        @(negedge clk);
        chk("R3 min css kept", css_m, 1);
        chk("R4 min pc full", pc_m, 32'h8000_0181);
        chk("R4 min isa zero", isa_m, 0);
        chk("R6 min ll cleared", ll_m, 0);
        chk("R5 full ll kept", ll_o, 1);
        chk("R3 full css restored", css_o, 2);
        chk("R7 min redirect", red_m, 1);

        // back-to-back requests: second pulse continues
        apply({7'b1000101, 4'd0, 4'd0, 4'd0, 32'h0, 32'h0000_0042}, 1'b1);
        @(negedge clk);
        chk("R7 back-to-back redirect", red_o, 1);
        chk("R1 back-to-back pc", pc_o, 32'h0000_0042);
        req = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule